// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and decides, once per instruction cycle, whether the core must divert into its service routine. Three core sources keep their flag and enable bits in one core register: the external pin, a pin-change event and a timer-overflow event. That register also holds a global enable and a peripheral-group enable. A set of up to eight peripheral sources keeps its flags in a second register and its enables in a third. Every flag latches when its event arrives, whatever the state of any enable. Software clears a flag by writing it.

The external pin passes through a two-flop synchronizer and an edge detector. The detector looks for the rising or the falling edge, as selected, and is silenced when the pin is configured as analog. When a request is taken, the controller drops the global enable, tells the core to push its return address, and presents the fixed vector 0x0004. A return strobe sets the global enable again, so any flag still pending is requested once more. A separate wake output tells the sleep logic that some source has both its flag and its own enable set, whatever the global and group enables are.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every register bit reads 0, and `take_o`, `push_ret_o`, `vec_pc_o` and `wake_o` are 0.
- R2: Address 0 is the core register, with bit 7 global enable, bit 6 peripheral-group enable, bit 5 timer-overflow enable, bit 4 pin enable, bit 3 pin-change enable, bit 2 timer-overflow flag, bit 1 pin flag and bit 0 pin-change flag. Address 1 holds the peripheral flags and address 2 the peripheral enables, with source i at bit i. Unused bits and address 3 read 0. A write takes effect at the clock edge that samples it.
- R3: A pulse on a source's event input sets that flag at the next clock edge, whatever the enables and the global enable are.
- R4: With `ext_rise_sel_i`=1 a rising pin edge sets the pin flag, and with 0 a falling edge does. The opposite edge has no effect. The flag is readable after the third clock edge following the pin change.
- R5: While `ext_analog_i` is 1, no pin transition sets the pin flag.
- R6: `take_o` pulses in the cycle after a clock in which `cyc_strobe_i`=1, the global enable is 1 and some source is pending. Without the strobe there is no take.
- R7: While `take_o` is 1, `push_ret_o` is 1, `vec_pc_o` is 0x0004 and the global enable already reads 0. `take_o` lasts one cycle.
- R8: A take does not clear any flag. A `ret_strobe_i` pulse sets the global enable, and a flag that is still set and enabled is then taken again.
- R9: A write that clears the global enable in the cycle where a take would be registered suppresses that take. The flag stays pending and is taken after the next return strobe.
- R10: When a hardware event and a software write clearing the same flag fall in one cycle, the flag ends at 1.
- R11: `wake_o` is 1 exactly when some flag and its own enable are both 1. It does not depend on the global or group enables.
- R12: A pending peripheral source requests a take only while the peripheral-group enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| ext_analog_i | input | 1 | Pin configured as analog; suppresses pin events |
| ext_rise_sel_i | input | 1 | 1 selects rising edges, 0 falling edges |
| chg_evt_i | input | 1 | Pin-change event pulse |
| tov_evt_i | input | 1 | Timer-overflow event pulse |
| per_evt_i | input | NPER | Peripheral event pulses |
| cyc_strobe_i | input | 1 | Instruction-cycle boundary from the core |
| ret_strobe_i | input | 1 | Return-from-interrupt strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| take_o | output | 1 | Interrupt taken, one-cycle pulse |
| push_ret_o | output | 1 | Push return address request |
| vec_pc_o | output | PC_W | Next program counter while taking, else 0 |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
The assertions assume that event inputs are synchronous single-cycle pulses and that register writes last one cycle. They also assume the core never raises the return strobe while a take is being registered, since a return happens only inside a service routine where the global enable is already 0. The stimulus drives every input on the falling clock edge. It pulses events and strobes for exactly one cycle and issues a return only after a take has completed. Only the external pin is driven as a level, and it goes through the synchronizer as designed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  localparam logic [AW-1:0] A_CORE = 2'd0;
  localparam logic [AW-1:0] A_PFLG = 2'd1;
  localparam logic [AW-1:0] A_PEN  = 2'd2;

  // Core register, bit 7 down to bit 0
  typedef struct packed {
    logic gen;
    logic pgen;
    logic tov_en;
    logic pin_en;
    logic chg_en;
    logic tov_f;
    logic pin_f;
    logic chg_f;
  } core_reg_t;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic analog_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q, sh_d;
  logic          synced, prev, rise, fall;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign synced = sh_q[LAST-1];
  assign prev   = sh_q[LAST];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;

  always_comb begin
    evt_o = (rise_sel_i ? rise : fall) & ~analog_i;
  end
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_pkg::*;
#(
  parameter int NPER = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            pin_evt_i,
  input  logic            chg_evt_i,
  input  logic            tov_evt_i,
  input  logic [NPER-1:0] per_evt_i,
  input  logic            take_i,
  input  logic            ret_i,
  output core_reg_t       core_q,
  output logic [NPER-1:0] pflag_q,
  output logic [NPER-1:0] pen_q
);
  core_reg_t       core_d;
  logic [NPER-1:0] pflag_d, pen_d;
  logic            wr_core, wr_pflg, wr_pen;

  assign wr_core = wr_i && (addr_i == A_CORE);
  assign wr_pflg = wr_i && (addr_i == A_PFLG);
  assign wr_pen  = wr_i && (addr_i == A_PEN);

  always_comb begin
    core_d = core_q;
    if (wr_core)    core_d = core_reg_t'(wdata_i);
    else if (ret_i) core_d.gen = 1'b1;
    if (take_i)     core_d.gen = 1'b0;
    if (pin_evt_i)  core_d.pin_f = 1'b1;
    if (chg_evt_i)  core_d.chg_f = 1'b1;
    if (tov_evt_i)  core_d.tov_f = 1'b1;
  end

  always_comb begin
    pflag_d = pflag_q;
    if (wr_pflg) pflag_d = wdata_i[NPER-1:0];
    pflag_d = pflag_d | per_evt_i;
    pen_d = pen_q;
    if (wr_pen) pen_d = wdata_i[NPER-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q  <= '0;
      pflag_q <= '0;
      pen_q   <= '0;
    end else begin
      core_q  <= core_d;
      pflag_q <= pflag_d;
      pen_q   <= pen_d;
    end
  end

  // R10: a hardware set always survives a simultaneous write
  p_hw_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tov_evt_i |=> core_q.tov_f);
  p_per_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt_i[0] |=> pflag_q[0]);
  // R8: return strobe restores the global enable
  p_ret_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && !wr_core) |=> core_q.gen);
  // R7: a take leaves the global enable cleared
  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !core_q.gen);
endmodule

// File: rtl/irq_take_gen.sv
module irq_take_gen
  import irq_pkg::*;
#(
  parameter int NPER = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  core_reg_t       core_i,
  input  logic [NPER-1:0] pflag_i,
  input  logic [NPER-1:0] pen_i,
  input  logic            strobe_i,
  input  logic            gen_clr_wr_i,
  output logic            take_d_o,
  output logic            take_q_o,
  output logic            wake_o
);
  logic core_hit, per_hit, pend, take_d;

  always_comb begin
    core_hit = (core_i.tov_f & core_i.tov_en) |
               (core_i.pin_f & core_i.pin_en) |
               (core_i.chg_f & core_i.chg_en);
    per_hit  = |(pflag_i & pen_i);
    pend     = core_hit | (core_i.pgen & per_hit);
    take_d   = strobe_i & core_i.gen & pend & ~gen_clr_wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) take_q_o <= 1'b0;
    else        take_q_o <= take_d;
  end

  assign take_d_o = take_d;
  assign wake_o   = core_hit | per_hit;

  // R6: a take needs the strobe, the global enable and a pending source
  p_take_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_q_o |-> ($past(strobe_i) && $past(core_i.gen) && $past(pend)));
  // R7: the take is a single-cycle pulse
  p_take_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_q_o |=> !take_q_o);
  // R12: a peripheral-only take needs the group enable
  p_group_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q_o && !$past(core_hit)) |-> $past(core_i.pgen));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NPER     = 7,
  parameter int PC_W     = 13,
  parameter int VEC_ADDR = 4,
  parameter int STAGES   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_pin_i,
  input  logic            ext_analog_i,
  input  logic            ext_rise_sel_i,
  input  logic            chg_evt_i,
  input  logic            tov_evt_i,
  input  logic [NPER-1:0] per_evt_i,
  input  logic            cyc_strobe_i,
  input  logic            ret_strobe_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic            take_o,
  output logic            push_ret_o,
  output logic [PC_W-1:0] vec_pc_o,
  output logic            wake_o
);
  localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

  core_reg_t       core_q;
  logic [NPER-1:0] pflag_q, pen_q;
  logic            pin_evt, take_d, take_q, gen_clr_wr;

  irq_pin_edge #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .analog_i(ext_analog_i),
    .rise_sel_i(ext_rise_sel_i), .evt_o(pin_evt)
  );

  irq_flag_regs #(.NPER(NPER)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pin_evt_i(pin_evt), .chg_evt_i(chg_evt_i),
    .tov_evt_i(tov_evt_i), .per_evt_i(per_evt_i), .take_i(take_d),
    .ret_i(ret_strobe_i), .core_q(core_q), .pflag_q(pflag_q), .pen_q(pen_q)
  );

  assign gen_clr_wr = reg_wr_i && (reg_addr_i == A_CORE) && !reg_wdata_i[7];

  irq_take_gen #(.NPER(NPER)) u_take (
    .clk(clk), .rst_n(rst_n), .core_i(core_q), .pflag_i(pflag_q),
    .pen_i(pen_q), .strobe_i(cyc_strobe_i), .gen_clr_wr_i(gen_clr_wr),
    .take_d_o(take_d), .take_q_o(take_q), .wake_o(wake_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CORE:  reg_rdata_o = core_q;
      A_PFLG:  reg_rdata_o[NPER-1:0] = pflag_q;
      A_PEN:   reg_rdata_o[NPER-1:0] = pen_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign take_o     = take_q;
  assign push_ret_o = take_q;
  assign vec_pc_o   = take_q ? VEC : '0;

  // R7: the global enable is already low while the take is presented
  p_take_gen_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !core_q.gen);
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int NPER = 7;
  localparam int PC_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pin = 1'b0, ext_analog = 1'b0, rise_sel = 1'b0;
  logic chg_evt = 1'b0, tov_evt = 1'b0;
  logic [NPER-1:0] per_evt = '0;
  logic cyc = 1'b1, ret = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rdata;
  logic take, push;
  logic [PC_W-1:0] vec;
  logic wake;

  int total = 0, bad = 0, takes = 0;
  bit done = 0;

  irq_ctrl #(.NPER(NPER), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .ext_analog_i(ext_analog),
    .ext_rise_sel_i(rise_sel), .chg_evt_i(chg_evt), .tov_evt_i(tov_evt),
    .per_evt_i(per_evt), .cyc_strobe_i(cyc), .ret_strobe_i(ret),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .take_o(take), .push_ret_o(push), .vec_pc_o(vec),
    .wake_o(wake)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  // take monitor: sample values held during the previous cycle
  always @(posedge clk) begin
    if (rst_n && take) begin
      takes++;
      chk(vec == PC_W'(4) && push, "R7 vector/push", int'(vec), 4);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    tick(3);
    // R1 reset state
    rd_chk(2'd0, 8'h00, "R1 core");
    rd_chk(2'd1, 8'h00, "R1 pflag");
    rd_chk(2'd2, 8'h00, "R1 pen");
    chk(!take && !push && vec == '0 && !wake, "R1 outputs", {take, push, wake}, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 register map
    wr(2'd1, 8'hFF); rd_chk(2'd1, 8'h7F, "R2 pflag width");
    wr(2'd2, 8'h55); rd_chk(2'd2, 8'h55, "R2 pen");
    rd_chk(2'd3, 8'h00, "R2 unused address");
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    wr(2'd0, 8'h38); rd_chk(2'd0, 8'h38, "R2 core enables");
    wr(2'd0, 8'h00);

    // core sources: R3, R6, R8
    for (int src = 0; src < 2; src++) begin
      for (int en = 0; en < 2; en++) begin
        logic [7:0] fb, eb, ex;
        fb = (src == 0) ? 8'h01 : 8'h04;
        eb = en ? ((src == 0) ? 8'h08 : 8'h20) : 8'h00;
        ex = fb | eb;
        wr(2'd0, eb);
        if (src == 0) chg_evt = 1'b1; else tov_evt = 1'b1;
        tick(1);
        chg_evt = 1'b0; tov_evt = 1'b0;
        rd_chk(2'd0, ex, "R3 flag sets with global off");
        base = takes;
        wr(2'd0, ex | 8'h80);
        tick(3);
        chk(takes - base == en, "R6 take on enabled source", takes - base, en);
        rd_chk(2'd0, en ? ex : (ex | 8'h80), "R8 flag kept, enable state");
        if (en) begin
          base = takes;
          ret = 1'b1; tick(1); ret = 1'b0;
          tick(3);
          chk(takes - base == 1, "R8 re-request after return", takes - base, 1);
          rd_chk(2'd0, ex, "R7 global cleared on take");
        end
        wr(2'd0, 8'h00);
      end
    end

    // peripheral sweep: R3, R11, R12
    for (int i = 0; i < NPER; i++) begin
      for (int pg = 0; pg < 2; pg++) begin
        for (int pe = 0; pe < 2; pe++) begin
          logic [7:0] bitv;
          bitv = 8'(1 << i);
          wr(2'd2, pe ? bitv : 8'h00);
          wr(2'd0, pg ? 8'h40 : 8'h00);
          per_evt = NPER'(1 << i);
          tick(1);
          per_evt = '0;
          rd_chk(2'd1, bitv, "R3 peripheral flag");
          chk(wake == pe[0], "R11 wake from own enable", wake, pe);
          base = takes;
          wr(2'd0, pg ? 8'hC0 : 8'h80);
          tick(3);
          chk(takes - base == (pg & pe), "R12 group gate", takes - base, pg & pe);
          wr(2'd1, 8'h00); wr(2'd0, 8'h00); wr(2'd2, 8'h00);
        end
      end
    end

    // external pin: R4, R5
    for (int sel = 0; sel < 2; sel++) begin
      for (int an = 0; an < 2; an++) begin
        rise_sel = sel[0]; ext_analog = an[0];
        ext_pin = ~sel[0];
        tick(6);
        wr(2'd0, 8'h00);
        ext_pin = sel[0];
        tick(2);
        rd_chk(2'd0, 8'h00, "R4 flag not before third edge");
        tick(1);
        rd_chk(2'd0, an ? 8'h00 : 8'h02, an ? "R5 analog blocks edge" : "R4 active edge sets flag");
        tick(4);
        wr(2'd0, 8'h00);
        ext_pin = ~sel[0];
        tick(6);
        rd_chk(2'd0, 8'h00, "R4 opposite edge ignored");
      end
    end
    ext_analog = 1'b0;

    // R9 suppression by a clearing write, R6 strobe gating
    cyc = 1'b0;
    base = takes;
    wr(2'd0, 8'hA4);
    tick(3);
    chk(takes == base, "R6 no take without strobe", takes - base, 0);
    cyc = 1'b1;
    wr(2'd0, 8'h24);
    tick(3);
    chk(takes == base, "R9 clearing write suppresses take", takes - base, 0);
    rd_chk(2'd0, 8'h24, "R9 request stays pending");
    ret = 1'b1; tick(1); ret = 1'b0;
    tick(3);
    chk(takes - base == 1, "R9 pending taken after return", takes - base, 1);
    rd_chk(2'd0, 8'h24, "R7 global low after take");
    wr(2'd0, 8'h00);

    // R10 hardware set beats software clear
    tov_evt = 1'b1;
    wr(2'd0, 8'h00);
    tov_evt = 1'b0;
    rd_chk(2'd0, 8'h04, "R10 core flag");
    per_evt = 7'h04;
    wr(2'd1, 8'h00);
    per_evt = '0;
    rd_chk(2'd1, 8'h04, "R10 peripheral flag");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R11 wake without global enable
    base = takes;
    wr(2'd0, 8'h12);
    tick(1);
    chk(wake == 1'b1, "R11 wake with pin enable", wake, 1);
    chk(takes == base, "R11 no take while global off", takes - base, 0);
    wr(2'd0, 8'h02);
    chk(wake == 1'b0, "R11 no wake without enable", wake, 0);
    wr(2'd0, 8'h00);
    tick(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule